// File: doc/BRIEF.md
# Boot ROM Mapper with External Image Signature Check

This block sits between a small embedded processor and its program memories. It turns every instruction fetch address into a read of either the on-chip ROM or an off-chip ROM, or flags it as outside the 48 KiB program space. A configuration strap chooses the boot source and is captured while reset is held. A live control bit then picks between an all-external map and a split map. In the split map the lower 32 KiB comes from the on-chip ROM and the next 16 KiB from the off-chip device over a 14-bit address.

When the strap selects on-chip boot, a short sequencer takes the external ROM bus after reset. It reads the last four bytes of the 64 KiB external space, one per clock. If all four hold the expected signature, the whole program space is switched to the external ROM and execution begins at external address 0x0000. At the first wrong byte the check stops and the on-chip ROM stays in use. Fetches are held off until the boot decision is made, which the processor sees on `boot_done_o`.

Top module: `boot_rom_map`

## Requirements
- R1: The strap input is sampled on every clock edge while `rst_n` is low and is held from the first edge with `rst_n` high; later strap changes do not alter the map.
- R2: With strap 0 and no signature match, every fetch below 0xC000 reads the on-chip ROM at the same address (`irom_rd_o`=1, `irom_addr_o`=fetch address, data from `irom_data_i`), whatever the split bit is.
- R3: With strap 1 and split bit 0, or after a signature match, every fetch below 0xC000 reads the external ROM with the full 16-bit address unchanged (`xrom_rd_o`=1, data from `xrom_data_i`).
- R4: With strap 1 and split bit 1, fetches in 0x0000..0x7FFF go to the on-chip ROM and fetches in 0x8000..0xBFFF go to the external ROM at address {2'b00, fetch[13:0]}. At most one of the two ROM strobes is high.
- R5: A fetch at 0xC000 or above returns 0xFF, raises `fetch_oor_o` and strobes neither ROM.
- R6: With strap 0, the cycle after reset release and the three cycles after it drive `xrom_rd_o`=1 with `xrom_addr_o` equal to 0xFFFC, 0xFFFD, 0xFFFE, 0xFFFF in that order, one address per cycle.
- R7: If the four bytes read are 0x89, 0xAB, 0xCD, 0xEF in that order, `boot_done_o` rises on the fourth edge after reset release and `boot_ext_o` reads 1.
- R8: At the first byte that differs (byte k, k=0..3), the check stops, `boot_done_o` rises on edge k+1 after release, and `boot_ext_o` stays 0.
- R9: While `boot_done_o` is 0, fetches are ignored: `fetch_data_o`=0xFF, `irom_rd_o`=0, `fetch_oor_o`=0.
- R10: With strap 1, no signature read happens and `boot_done_o` rises on the first edge after reset release. `boot_ext_o` is 1 when the split bit is 0 and 0 when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_ext_i | input | 1 | Boot source strap: 0 on-chip, 1 external |
| split_en_i | input | 1 | Control bit: split map when strap is 1 |
| fetch_addr_i | input | 16 | Processor fetch address |
| fetch_rd_i | input | 1 | Processor fetch strobe |
| fetch_data_o | output | 8 | Fetched byte (0xFF when nothing is read) |
| fetch_oor_o | output | 1 | Fetch address beyond program space |
| irom_addr_o | output | 16 | On-chip ROM address |
| irom_rd_o | output | 1 | On-chip ROM read strobe |
| irom_data_i | input | 8 | On-chip ROM data (combinational read) |
| xrom_addr_o | output | 16 | External ROM address |
| xrom_rd_o | output | 1 | External ROM read strobe |
| xrom_data_i | input | 8 | External ROM data (combinational read) |
| boot_done_o | output | 1 | Boot decision made, fetches served |
| boot_ext_o | output | 1 | Address 0x0000 is served from the external ROM |

## Verification
A sequencer that skips, repeats or reorders a signature byte shows on `xrom_addr_o` within one cycle of reset release. A miscounted index or a lost mismatch moves the rising edge of `boot_done_o` or flips `boot_ext_o` within four cycles. A wrong map-mode state is visible on the very next fetch as the wrong ROM strobe, address or data byte. A strap that is not held shows up when the strap input toggles after reset and the following fetches still have to follow the captured value.

// File: rtl/boot_map_pkg.sv
// Shared types for the boot ROM mapper.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package boot_map_pkg;

    // Program space map currently in force.
    typedef enum logic [1:0] {
        MAP_INT   = 2'd0,  // everything from on-chip ROM
        MAP_EXT   = 2'd1,  // everything from external ROM, full address
        MAP_SPLIT = 2'd2   // low part on-chip, upper part external
    } map_mode_e;

    // Signature sequencer state.
    typedef enum logic {
        SEQ_CHECK = 1'b0,
        SEQ_DONE  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/rom_sig_seq.sv
// Signature sequencer: after reset, when enabled, reads SIG_LEN bytes of
// the external ROM starting at SIG_BASE, one byte per cycle, and compares
// them with SIG_VAL (first byte in the most significant slot). It stops at
// the first mismatch. Assumes the external ROM answers combinationally.
module rom_sig_seq
    import boot_map_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int SIG_LEN = 4,
    parameter logic [ADDR_W-1:0] SIG_BASE = 16'hFFFC,
    parameter logic [SIG_LEN*DATA_W-1:0] SIG_VAL = 32'h89ABCDEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              check_en_i,
    input  logic [DATA_W-1:0] xdata_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] sig_addr_o,
    output logic              done_o,
    output logic              match_o
);

    localparam int IDX_W = (SIG_LEN > 1) ? $clog2(SIG_LEN) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SIG_LEN - 1);

    seq_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic              match_q;
    logic [DATA_W-1:0] want;

    // Expected byte for the current index.
    always_comb begin
        want = SIG_VAL[(SIG_LEN - 1 - int'(idx_q)) * DATA_W +: DATA_W];
    end

    // Walk the signature, stop on mismatch or after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_CHECK;
            idx_q   <= '0;
            match_q <= 1'b0;
        end else if (state_q == SEQ_CHECK) begin
            if (!check_en_i || xdata_i != want) begin
                state_q <= SEQ_DONE;
            end else if (idx_q == LAST) begin
                state_q <= SEQ_DONE;
                match_q <= 1'b1;
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    assign busy_o     = (state_q == SEQ_CHECK) && check_en_i;
    assign sig_addr_o = SIG_BASE + ADDR_W'(idx_q);
    assign done_o     = (state_q == SEQ_DONE);
    assign match_o    = match_q;

    // R6: consecutive read cycles step the address by one
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && busy_o && $past(busy_o)) |->
            sig_addr_o == $past(sig_addr_o) + ADDR_W'(1));

    // R7: once made, the boot decision never reverts
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(done_o)) |-> done_o);

    // R8: a finished check never changes its verdict
    a_r8_verdict_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(done_o)) |-> $stable(match_o));

endmodule

// File: rtl/rom_map.sv
// Fetch address decoder: steers an enabled fetch to the on-chip or the
// external ROM according to the map mode, or flags it as out of range.
// Assumes both ROMs return data combinationally from the address.
module rom_map
    import boot_map_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int PROG_BYTES = 49152,
    parameter int SPLIT_BASE = 32768,
    parameter int SPLIT_XW   = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  map_mode_e         mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] idata_i,
    input  logic [DATA_W-1:0] xdata_i,
    output logic              ird_o,
    output logic [ADDR_W-1:0] iaddr_o,
    output logic              xrd_o,
    output logic [ADDR_W-1:0] xaddr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              oor_o
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(PROG_BYTES);
    localparam logic [ADDR_W:0] SPLIT = (ADDR_W + 1)'(SPLIT_BASE);

    logic in_range;
    logic low_part;

    assign in_range = {1'b0, addr_i} < LIMIT;
    assign low_part = {1'b0, addr_i} < SPLIT;
    assign iaddr_o  = addr_i;

    // Select the source for this fetch and its external address.
    always_comb begin
        ird_o   = 1'b0;
        xrd_o   = 1'b0;
        xaddr_o = addr_i;
        data_o  = '1;
        oor_o   = 1'b0;
        if (en_i && rd_i) begin
            if (!in_range) begin
                oor_o = 1'b1;
            end else begin
                unique case (mode_i)
                    MAP_INT: begin
                        ird_o  = 1'b1;
                        data_o = idata_i;
                    end
                    MAP_SPLIT: begin
                        if (low_part) begin
                            ird_o  = 1'b1;
                            data_o = idata_i;
                        end else begin
                            xrd_o   = 1'b1;
                            xaddr_o = ADDR_W'(addr_i[SPLIT_XW-1:0]);
                            data_o  = xdata_i;
                        end
                    end
                    default: begin
                        xrd_o  = 1'b1;
                        data_o = xdata_i;
                    end
                endcase
            end
        end
    end

    // R5: an out-of-range fetch strobes no ROM
    a_r5_oor_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        oor_o |-> (!ird_o && !xrd_o));

    // R4: a fetch has at most one outcome
    a_r4_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ird_o, xrd_o, oor_o}));

endmodule

// File: rtl/boot_rom_map.sv
// Boot ROM mapper top: captures the boot strap during reset, runs the
// external signature check when booting on-chip, then decodes fetches.
// The external ROM bus belongs to the sequencer until the boot decision.
// Assumes synchronous active-low reset held for at least one clock.
module boot_rom_map
    import boot_map_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int PROG_BYTES = 49152,
    parameter int SPLIT_BASE = 32768,
    parameter int SPLIT_XW   = 14,
    parameter int SIG_LEN    = 4,
    parameter logic [ADDR_W-1:0] SIG_BASE = 16'hFFFC,
    parameter logic [SIG_LEN*DATA_W-1:0] SIG_VAL = 32'h89ABCDEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_ext_i,
    input  logic              split_en_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    input  logic              fetch_rd_i,
    output logic [DATA_W-1:0] fetch_data_o,
    output logic              fetch_oor_o,
    output logic [ADDR_W-1:0] irom_addr_o,
    output logic              irom_rd_o,
    input  logic [DATA_W-1:0] irom_data_i,
    output logic [ADDR_W-1:0] xrom_addr_o,
    output logic              xrom_rd_o,
    input  logic [DATA_W-1:0] xrom_data_i,
    output logic              boot_done_o,
    output logic              boot_ext_o
);

    logic              strap_q;
    logic              seq_busy;
    logic [ADDR_W-1:0] seq_addr;
    logic              seq_done;
    logic              seq_match;
    map_mode_e         mode;
    logic              map_xrd;
    logic [ADDR_W-1:0] map_xaddr;

    // Capture the strap while reset is held, keep it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q <= strap_ext_i;
        end
    end

    // Map mode from captured strap, control bit and signature verdict.
    always_comb begin
        if (!strap_q) begin
            mode = seq_match ? MAP_EXT : MAP_INT;
        end else begin
            mode = split_en_i ? MAP_SPLIT : MAP_EXT;
        end
    end

    rom_sig_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SIG_LEN (SIG_LEN),
        .SIG_BASE(SIG_BASE),
        .SIG_VAL (SIG_VAL)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .check_en_i(!strap_q),
        .xdata_i   (xrom_data_i),
        .busy_o    (seq_busy),
        .sig_addr_o(seq_addr),
        .done_o    (seq_done),
        .match_o   (seq_match)
    );

    rom_map #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PROG_BYTES(PROG_BYTES),
        .SPLIT_BASE(SPLIT_BASE),
        .SPLIT_XW  (SPLIT_XW)
    ) i_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (seq_done),
        .mode_i (mode),
        .addr_i (fetch_addr_i),
        .rd_i   (fetch_rd_i),
        .idata_i(irom_data_i),
        .xdata_i(xrom_data_i),
        .ird_o  (irom_rd_o),
        .iaddr_o(irom_addr_o),
        .xrd_o  (map_xrd),
        .xaddr_o(map_xaddr),
        .data_o (fetch_data_o),
        .oor_o  (fetch_oor_o)
    );

    // External bus owner: sequencer during the check, decoder afterwards.
    assign xrom_addr_o = seq_busy ? seq_addr : map_xaddr;
    assign xrom_rd_o   = seq_busy | map_xrd;
    assign boot_done_o = seq_done;
    assign boot_ext_o  = seq_done && (mode == MAP_EXT);

    // R1: captured strap holds once reset has been released
    a_r1_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q));

    // R9: no fetch is served before the boot decision
    a_r9_quiet_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_done_o |-> (!irom_rd_o && !fetch_oor_o));

    // R6: the signature check always drives the external read strobe
    a_r6_bus_owner: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> (xrom_rd_o && !irom_rd_o));

endmodule

// File: tb/test_boot_rom_map.sv
`timescale 1ns/100ps
module test_boot_rom_map;

    localparam int M_INT   = 0;
    localparam int M_EXT   = 1;
    localparam int M_SPLIT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_ext_i = 1'b0;
    logic        split_en_i = 1'b0;
    logic [15:0] fetch_addr_i = '0;
    logic        fetch_rd_i = 1'b0;
    logic [7:0]  fetch_data_o;
    logic        fetch_oor_o;
    logic [15:0] irom_addr_o;
    logic        irom_rd_o;
    logic [7:0]  irom_data_i;
    logic [15:0] xrom_addr_o;
    logic        xrom_rd_o;
    logic [7:0]  xrom_data_i;
    logic        boot_done_o;
    logic        boot_ext_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [7:0] sig_img [4];

    always #2.5 clk = ~clk;

    boot_rom_map i_boot_rom_map (.*);

    function automatic logic [7:0] irom_byte(input logic [15:0] a);
        return 8'(a[7:0] + 8'(3 * a[15:8]));
    endfunction

    function automatic logic [7:0] xrom_byte(input logic [15:0] a);
        if (a >= 16'hFFFC) return sig_img[a - 16'hFFFC];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always_comb irom_data_i = irom_byte(irom_addr_o);
    always_comb xrom_data_i = xrom_byte(xrom_addr_o);

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected port view of one fetch after boot, from the requirements.
    function automatic logic [63:0] model(input logic [15:0] a, input bit rd,
                                          input int mode);
        logic ird, xrd, oor;
        logic [15:0] xa, ia;
        logic [7:0] d;
        ird = 0; xrd = 0; oor = 0; xa = 0; ia = 0; d = 8'hFF;
        if (rd) begin
            if (a >= 16'hC000) oor = 1;                              // R5
            else if (mode == M_INT || (mode == M_SPLIT && a < 16'h8000)) begin
                ird = 1; ia = a; d = irom_byte(a);                   // R2, R4
            end else begin
                xrd = 1;
                xa = (mode == M_SPLIT) ? {2'b00, a[13:0]} : a;      // R3, R4
                d = xrom_byte(xa);
            end
        end
        return {13'd0, ird, xrd, oor, d, ia, xa};
    endfunction

    function automatic logic [63:0] observe();
        return {13'd0, irom_rd_o, xrom_rd_o, fetch_oor_o, fetch_data_o,
                irom_rd_o ? irom_addr_o : 16'h0,
                xrom_rd_o ? xrom_addr_o : 16'h0};
    endfunction

    task automatic fetch(input logic [15:0] a, input bit rd, input int mode,
                         input string req);
        logic [63:0] e, o;
        @(negedge clk);
        fetch_addr_i = a;
        fetch_rd_i   = rd;
        #1;
        e = model(a, rd, mode);
        o = observe();
        chk(o == e, req, o, e);
    endtask

    // Reset, then follow the boot sequence and check its timing.
    task automatic boot(input bit strap, input bit split, input logic [31:0] sig);
        bit good;
        int bad_k;
        for (int i = 0; i < 4; i++) sig_img[i] = sig[31 - 8*i -: 8];
        @(negedge clk);
        rst_n = 0; strap_ext_i = strap; split_en_i = split; fetch_rd_i = 0;
        repeat (3) @(negedge clk);
        fetch_rd_i = 1; fetch_addr_i = 16'h0010;
        #1;
        chk(!boot_done_o && fetch_data_o == 8'hFF && !irom_rd_o, "R9 reset state",
            {boot_done_o, fetch_data_o}, {1'b0, 8'hFF});
        @(negedge clk);
        rst_n = 1;
        if (strap) begin
            #1;
            chk(!boot_done_o && !xrom_rd_o, "R10 no signature read",
                {boot_done_o, xrom_rd_o}, 0);
            @(negedge clk); #1;
            chk(boot_done_o && boot_ext_o == !split, "R10 done after one edge",
                {boot_done_o, boot_ext_o}, {1'b1, !split});
            return;
        end
        good = 1; bad_k = 4;
        for (int k = 0; k < 4; k++) begin
            if (good) begin
                fetch_addr_i = 16'($urandom_range(0, 16'hFFFF));
                fetch_rd_i = 1;
                #1;
                chk(xrom_rd_o && xrom_addr_o == 16'hFFFC + 16'(k) && !boot_done_o,
                    "R6 signature address", {xrom_rd_o, xrom_addr_o, boot_done_o},
                    {1'b1, 16'hFFFC + 16'(k), 1'b0});
                chk(fetch_data_o == 8'hFF && !irom_rd_o && !fetch_oor_o,
                    "R9 fetch ignored", {fetch_data_o, irom_rd_o, fetch_oor_o},
                    {8'hFF, 2'b00});
                if (sig_img[k] != (32'h89ABCDEF >> (24 - 8*k)) % 256) begin
                    good = 0; bad_k = k;
                end
                @(negedge clk);
            end
        end
        fetch_rd_i = 0;
        #1;
        if (good)
            chk(boot_done_o && boot_ext_o, "R7 match selects external",
                {boot_done_o, boot_ext_o}, 2'b11);
        else
            chk(boot_done_o && !boot_ext_o, $sformatf("R8 mismatch at byte %0d", bad_k),
                {boot_done_o, boot_ext_o}, 2'b10);
    endtask

    task automatic rand_fetches(input int n, input int mode, input string req);
        for (int i = 0; i < n; i++)
            fetch(16'($urandom_range(0, 16'hFFFF)), ($urandom_range(0, 7) != 0), mode, req);
    endtask

    initial begin
        void'($urandom(32'd2121));
        // full signature match: external image
        boot(0, 1, 32'h89ABCDEF);
        rand_fetches(40, M_EXT, "R7 external after match");
        fetch(16'hBFFF, 1, M_EXT, "R3 top of space");
        fetch(16'hC000, 1, M_EXT, "R5 first out-of-range");
        // mismatch at each position
        boot(0, 0, 32'h00ABCDEF);
        rand_fetches(30, M_INT, "R2 internal after mismatch");
        boot(0, 1, 32'h8900CDEF);
        rand_fetches(10, M_INT, "R8 internal with split bit set");
        boot(0, 0, 32'h89AB00EF);
        fetch(16'h0000, 1, M_INT, "R8 vector internal");
        boot(0, 0, 32'h89ABCD00);
        fetch(16'hBFFF, 1, M_INT, "R2 top of space");
        fetch(16'hFFFF, 1, M_INT, "R5 last address");
        // strap external, full map, then strap toggles after reset
        boot(1, 0, 32'h0);
        rand_fetches(30, M_EXT, "R3 all external");
        @(negedge clk); strap_ext_i = 0;
        rand_fetches(10, M_EXT, "R1 strap change ignored");
        // strap external, split map, boundaries
        boot(1, 1, 32'h89ABCDEF);
        fetch(16'h7FFF, 1, M_SPLIT, "R4 last internal");
        fetch(16'h8000, 1, M_SPLIT, "R4 first external");
        fetch(16'hBFFF, 1, M_SPLIT, "R4 last external");
        fetch(16'hC000, 1, M_SPLIT, "R5 split out-of-range");
        rand_fetches(40, M_SPLIT, "R4 split map");
        // live split bit switches the map
        @(negedge clk); split_en_i = 0;
        fetch(16'h1234, 1, M_EXT, "R3 split bit cleared");
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule